// File: doc/BRIEF.md
# Resistive Touch Panel Step Sequencer

This block schedules the conversions for a resistive touch panel with four, five or eight wires. Software fills a table of up to fourteen step slots. Each slot holds a configuration word and an open-delay word. The configuration word chooses:

- which panel drivers are switched on,
- the ADC input to sample,
- whether the step waits for the pen-detect trigger,
- which of two result FIFOs receives the conversion.

A start pulse walks the enabled slots from the lowest number upward and may add a charge step at the end. The block then clears its own enable mask, so software must re-arm it before the next run. Between runs the panel is driven with an idle pattern, and the step-ID output reads 0x10.

The sequencer is a single state machine. Its states are:

- IDLE (idle drive, waiting for start).
- SYNC (step drivers on; waiting for pen-down when the step asks for it).
- OPEN (open-delay countdown).
- CONV (one-cycle ADC start).
- WAIT (waiting for the ADC done strobe; the result is written to a FIFO here).
- CHARGE (charge drive and its countdown).

Its transitions are:

- IDLE→SYNC on start when a step is enabled.
- IDLE→CHARGE on start when only the charge bit is set.
- SYNC→OPEN when no wait is needed or the pen is down.
- OPEN→CONV when the count reaches zero.
- CONV→WAIT always.
- WAIT→SYNC on done when a further step is enabled.
- WAIT→CHARGE on done when the charge bit is set.
- WAIT→IDLE on done otherwise.
- CHARGE→IDLE when the count reaches zero.

Reaching IDLE from WAIT or CHARGE ends the sequence.

A small interrupt unit tracks how many entries FIFO1 holds. It sets a threshold flag when that count reaches the programmed level, and sets a pen-up flag when a sequence ends with the pen lifted. Both flags are write-one-to-clear and are visible whatever the interrupt mask holds.

Top module: `touch_step_seq`

## Requirements
- R1: After reset, step_id is 0x10, panel_drv is 0, adc_start, fifo0_wr, fifo1_wr and irq are 0, and irq_raw is 0.
- R2: A start pulse runs every step whose enable bit is set, in ascending step order, and skips the others. The enable register is at address 0: bit 0 enables the charge step, and bits 1 to 14 enable steps 1 to 14.
- R3: Step n's configuration word is at address 16+n and its delay word (bits [7:0]) at 32+n. Configuration bit 26 set sends the result to FIFO1 (fifo1_wr); clear sends it to FIFO0 (fifo0_wr). Each adc_done in WAIT gives exactly one strobe, with fifo_wdata = {step[3:0], adc_data[11:0]}.
- R4: step_id shows the step number while a step runs, 0x0F during the charge step, and 0x10 when idle.
- R5: panel_drv comes from the driver field, bits [10:5]: from the idle word (address 3) when idle, from the step word while a step runs, and from the charge word (address 1) during the charge step. adc_chan carries the step word's bits [19:16] while a step runs.
- R6: adc_start is a one-cycle pulse that rises exactly delay+2 cycles after step_id first shows the step.
- R7: A step whose mode field, bits [1:0], equals 2 stays in SYNC with no adc_start until pen_down is high.
- R8: With enable bit 0 set, the charge step follows the last enabled step and lasts (charge delay, address 2) + 1 cycles.
- R9: The enable mask clears when a sequence ends, so a later start has no effect until the mask is rewritten.
- R10: irq_raw[0] sets when the FIFO1 count reaches the threshold (address 4, default 6). A fifo1_pop lowers the count.
- R11: irq_raw[1] sets when a sequence ends with pen_down low, and stays clear when the pen is down at the end.
- R12: Writing 1 to a bit of address 5 clears that irq_raw bit and leaves the other bit unchanged. The interrupt enable is at address 6. irq is the OR of irq_raw AND enable, and irq_raw updates with the enable at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register address |
| wr_data | input | 32 | Register write data |
| start | input | 1 | Sequence start pulse |
| pen_down | input | 1 | Pen-detect level |
| adc_done | input | 1 | ADC conversion complete |
| adc_data | input | 12 | ADC result |
| fifo1_pop | input | 1 | One entry read from FIFO1 |
| adc_start | output | 1 | ADC conversion request |
| adc_chan | output | 4 | ADC input select |
| panel_drv | output | 6 | Panel driver switch enables |
| fifo0_wr | output | 1 | Write strobe for FIFO0 |
| fifo1_wr | output | 1 | Write strobe for FIFO1 |
| fifo_wdata | output | 16 | Tagged result word |
| step_id | output | 5 | Current step number, 0x10 when idle |
| irq_raw | output | 2 | Raw flags: [0] threshold, [1] pen-up |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume that adc_done arrives only while a conversion is outstanding, as a single-cycle pulse after adc_start. They also assume that the step table and enable mask are rewritten only while the sequencer is idle. The bench models the ADC so that it answers three cycles after each start with a one-cycle done. It changes pen_down and performs register writes only between sequences, or while a step is parked waiting for pen-down.

// File: rtl/touch_seq_pkg.sv
package touch_seq_pkg;
    localparam int STEP_W = 4;
    localparam int DRV_W  = 6;
    localparam int CHAN_W = 4;
    localparam int ID_W   = STEP_W + 1;
    localparam logic [ID_W-1:0] ID_IDLE   = 5'h10;
    localparam logic [ID_W-1:0] ID_CHARGE = 5'h0F;
    localparam logic [1:0] MODE_HWSYNC = 2'd2;

    localparam int A_ENABLE   = 0;
    localparam int A_CHG_CFG  = 1;
    localparam int A_CHG_DLY  = 2;
    localparam int A_IDLE_CFG = 3;
    localparam int A_THRESH   = 4;
    localparam int A_STATUS   = 5;
    localparam int A_IRQ_EN   = 6;
    localparam int A_CFG_BASE = 16;
    localparam int A_DLY_BASE = 32;

    typedef struct packed {
        logic              fsel;
        logic [CHAN_W-1:0] chan;
        logic [DRV_W-1:0]  drv;
        logic [1:0]        mode;
    } step_cfg_t;

    typedef enum logic [2:0] {
        S_IDLE, S_SYNC, S_OPEN, S_CONV, S_WAIT, S_CHARGE
    } seq_state_t;

    function automatic step_cfg_t unpack_cfg(input logic [31:0] w);
        step_cfg_t c;
        c.mode = w[1:0];
        c.drv  = w[10:5];
        c.chan = w[19:16];
        c.fsel = w[26];
        return c;
    endfunction

    // lowest enabled step strictly above cur; {found, index}
    function automatic logic [STEP_W:0] next_step(input logic [15:0] mask,
                                                  input logic [STEP_W-1:0] cur,
                                                  input int n);
        logic [STEP_W:0] r;
        r = '0;
        for (int i = n; i >= 1; i--) begin
            if (mask[i] && (STEP_W'(i) > cur)) r = {1'b1, STEP_W'(i)};
        end
        return r;
    endfunction
endpackage

// File: rtl/touch_step_table.sv
module touch_step_table
    import touch_seq_pkg::*;
#(
    parameter int NSTEPS = 14,
    parameter int DLY_W  = 8,
    parameter int ADDR_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [31:0]           wr_data,
    input  logic                  seq_done,
    input  logic [STEP_W-1:0]     rd_idx,
    output step_cfg_t             rd_cfg,
    output logic [DLY_W-1:0]      rd_dly,
    output logic [NSTEPS:0]       en_mask,
    output logic [DRV_W-1:0]      chg_drv,
    output logic [DLY_W-1:0]      chg_dly,
    output logic [DRV_W-1:0]      idle_drv
);
    step_cfg_t        cfg_q [NSTEPS+1];
    logic [DLY_W-1:0] dly_q [NSTEPS+1];
    logic             en_wr;

    assign en_wr = wr_en && (wr_addr == ADDR_W'(A_ENABLE));

    for (genvar s = 0; s <= NSTEPS; s++) begin : g_slot
        if (s == 0) begin : g_null
            assign cfg_q[s] = '0;
            assign dly_q[s] = '0;
        end else begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cfg_q[s] <= '0;
                    dly_q[s] <= '0;
                end else if (wr_en) begin
                    if (wr_addr == ADDR_W'(A_CFG_BASE + s)) cfg_q[s] <= unpack_cfg(wr_data);
                    if (wr_addr == ADDR_W'(A_DLY_BASE + s)) dly_q[s] <= wr_data[DLY_W-1:0];
                end
            end
        end
    end

    always_comb begin
        rd_cfg = '0;
        rd_dly = '0;
        for (int s = 0; s <= NSTEPS; s++) begin
            if (rd_idx == STEP_W'(s)) begin
                rd_cfg = cfg_q[s];
                rd_dly = dly_q[s];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_mask  <= '0;
            chg_drv  <= '0;
            chg_dly  <= '0;
            idle_drv <= '0;
        end else begin
            if (en_wr)         en_mask <= wr_data[NSTEPS:0];
            else if (seq_done) en_mask <= '0;
            if (wr_en && wr_addr == ADDR_W'(A_CHG_CFG))  chg_drv  <= wr_data[10:5];
            if (wr_en && wr_addr == ADDR_W'(A_CHG_DLY))  chg_dly  <= wr_data[DLY_W-1:0];
            if (wr_en && wr_addr == ADDR_W'(A_IDLE_CFG)) idle_drv <= wr_data[10:5];
        end
    end

    AST_EN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && !en_wr) |=> (en_mask == '0)); // R9
endmodule

// File: rtl/touch_seq_fsm.sv
module touch_seq_fsm
    import touch_seq_pkg::*;
#(
    parameter int NSTEPS = 14,
    parameter int DLY_W  = 8,
    parameter int ADC_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     pen_down,
    input  logic                     adc_done,
    input  logic [ADC_W-1:0]         adc_data,
    input  logic [NSTEPS:0]          en_mask,
    input  step_cfg_t                cur_cfg,
    input  logic [DLY_W-1:0]         cur_dly,
    input  logic [DRV_W-1:0]         chg_drv,
    input  logic [DLY_W-1:0]         chg_dly,
    input  logic [DRV_W-1:0]         idle_drv,
    output logic [STEP_W-1:0]        cur_idx,
    output logic                     seq_done,
    output logic                     pen_up_evt,
    output logic                     adc_start,
    output logic [CHAN_W-1:0]        adc_chan,
    output logic [DRV_W-1:0]         panel_drv,
    output logic                     fifo0_wr,
    output logic                     fifo1_wr,
    output logic [STEP_W+ADC_W-1:0]  fifo_wdata,
    output logic [ID_W-1:0]          step_id
);
    seq_state_t        state_q, state_d;
    logic [STEP_W-1:0] cur_q, cur_d;
    logic [DLY_W-1:0]  cnt_q, cnt_d;
    logic [STEP_W:0]   nxt;

    assign nxt     = next_step(16'(en_mask), cur_q, NSTEPS);
    assign cur_idx = cur_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cur_d    = cur_q;
        cnt_d    = cnt_q;
        seq_done = 1'b0;
        unique case (state_q)
            S_IDLE: if (start) begin
                if (nxt[STEP_W]) begin
                    cur_d   = nxt[STEP_W-1:0];
                    state_d = S_SYNC;
                end else if (en_mask[0]) begin
                    cnt_d   = chg_dly;
                    state_d = S_CHARGE;
                end
            end
            S_SYNC: if (cur_cfg.mode != MODE_HWSYNC || pen_down) begin
                cnt_d   = cur_dly;
                state_d = S_OPEN;
            end
            S_OPEN: begin
                if (cnt_q == '0) state_d = S_CONV;
                else             cnt_d   = cnt_q - 1'b1;
            end
            S_CONV: state_d = S_WAIT;
            S_WAIT: if (adc_done) begin
                if (nxt[STEP_W]) begin
                    cur_d   = nxt[STEP_W-1:0];
                    state_d = S_SYNC;
                end else if (en_mask[0]) begin
                    cur_d   = '0;
                    cnt_d   = chg_dly;
                    state_d = S_CHARGE;
                end else begin
                    cur_d    = '0;
                    seq_done = 1'b1;
                    state_d  = S_IDLE;
                end
            end
            S_CHARGE: begin
                if (cnt_q == '0) begin
                    seq_done = 1'b1;
                    state_d  = S_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign pen_up_evt = seq_done && !pen_down;

    always_comb begin
        adc_start  = 1'b0;
        adc_chan   = '0;
        panel_drv  = idle_drv;
        step_id    = ID_IDLE;
        fifo0_wr   = 1'b0;
        fifo1_wr   = 1'b0;
        fifo_wdata = {cur_q, adc_data};
        unique case (state_q)
            S_SYNC, S_OPEN, S_CONV, S_WAIT: begin
                step_id   = {1'b0, cur_q};
                panel_drv = cur_cfg.drv;
                adc_chan  = cur_cfg.chan;
                adc_start = (state_q == S_CONV);
                if (state_q == S_WAIT) begin
                    fifo1_wr = adc_done && cur_cfg.fsel;
                    fifo0_wr = adc_done && !cur_cfg.fsel;
                end
            end
            S_CHARGE: begin
                step_id   = ID_CHARGE;
                panel_drv = chg_drv;
            end
            default: ;
        endcase
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start); // R6
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> (step_id == ID_IDLE)); // R4
    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SYNC && cur_cfg.mode == MODE_HWSYNC && !pen_down)
            |=> ($stable(step_id) && !adc_start)); // R7
endmodule

// File: rtl/touch_irq_ctl.sv
module touch_irq_ctl
    import touch_seq_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int DEF_THR    = 6,
    parameter int ADDR_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              fifo1_wr,
    input  logic              fifo1_pop,
    input  logic              pen_up_evt,
    output logic [1:0]        irq_raw,
    output logic              irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic [CNT_W-1:0] cnt_q, cnt_d, thr_q;
    logic [1:0]       raw_q, en_q, clr;
    logic             thr_set;

    always_comb begin
        cnt_d = cnt_q;
        if (fifo1_wr && cnt_q != CNT_W'(FIFO_DEPTH)) cnt_d = cnt_d + 1'b1;
        if (fifo1_pop && cnt_q != '0)               cnt_d = cnt_d - 1'b1;
    end

    assign thr_set = (cnt_q < thr_q) && (cnt_d >= thr_q);
    assign clr     = (wr_en && wr_addr == ADDR_W'(A_STATUS)) ? wr_data[1:0] : 2'b00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            thr_q <= CNT_W'(DEF_THR);
            raw_q <= '0;
            en_q  <= '0;
        end else begin
            cnt_q <= cnt_d;
            raw_q <= (raw_q & ~clr) | {pen_up_evt, thr_set};
            if (wr_en && wr_addr == ADDR_W'(A_THRESH)) thr_q <= wr_data[CNT_W-1:0];
            if (wr_en && wr_addr == ADDR_W'(A_IRQ_EN)) en_q  <= wr_data[1:0];
        end
    end

    assign irq_raw = raw_q;
    assign irq     = |(raw_q & en_q);

    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[0] && !thr_set) |=> !irq_raw[0]); // R12
    AST_THR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo1_wr && !fifo1_pop && cnt_q == thr_q - 1'b1 && thr_q != '0) |=> irq_raw[0]); // R10
endmodule

// File: rtl/touch_step_seq.sv
module touch_step_seq
    import touch_seq_pkg::*;
#(
    parameter int NSTEPS     = 14,
    parameter int DLY_W      = 8,
    parameter int ADC_W      = 12,
    parameter int ADDR_W     = 6,
    parameter int FIFO_DEPTH = 64,
    parameter int DEF_THR    = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [31:0]             wr_data,
    input  logic                    start,
    input  logic                    pen_down,
    input  logic                    adc_done,
    input  logic [ADC_W-1:0]        adc_data,
    input  logic                    fifo1_pop,
    output logic                    adc_start,
    output logic [CHAN_W-1:0]       adc_chan,
    output logic [DRV_W-1:0]        panel_drv,
    output logic                    fifo0_wr,
    output logic                    fifo1_wr,
    output logic [STEP_W+ADC_W-1:0] fifo_wdata,
    output logic [ID_W-1:0]         step_id,
    output logic [1:0]              irq_raw,
    output logic                    irq
);
    step_cfg_t         cur_cfg;
    logic [DLY_W-1:0]  cur_dly, chg_dly;
    logic [NSTEPS:0]   en_mask;
    logic [DRV_W-1:0]  chg_drv, idle_drv;
    logic [STEP_W-1:0] cur_idx;
    logic              seq_done, pen_up_evt;

    touch_step_table #(.NSTEPS(NSTEPS), .DLY_W(DLY_W), .ADDR_W(ADDR_W)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .seq_done(seq_done), .rd_idx(cur_idx), .rd_cfg(cur_cfg), .rd_dly(cur_dly),
        .en_mask(en_mask), .chg_drv(chg_drv), .chg_dly(chg_dly), .idle_drv(idle_drv)
    );

    touch_seq_fsm #(.NSTEPS(NSTEPS), .DLY_W(DLY_W), .ADC_W(ADC_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .pen_down(pen_down),
        .adc_done(adc_done), .adc_data(adc_data), .en_mask(en_mask),
        .cur_cfg(cur_cfg), .cur_dly(cur_dly), .chg_drv(chg_drv), .chg_dly(chg_dly),
        .idle_drv(idle_drv), .cur_idx(cur_idx), .seq_done(seq_done),
        .pen_up_evt(pen_up_evt), .adc_start(adc_start), .adc_chan(adc_chan),
        .panel_drv(panel_drv), .fifo0_wr(fifo0_wr), .fifo1_wr(fifo1_wr),
        .fifo_wdata(fifo_wdata), .step_id(step_id)
    );

    touch_irq_ctl #(.FIFO_DEPTH(FIFO_DEPTH), .DEF_THR(DEF_THR), .ADDR_W(ADDR_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fifo1_wr(fifo1_wr), .fifo1_pop(fifo1_pop), .pen_up_evt(pen_up_evt),
        .irq_raw(irq_raw), .irq(irq)
    );
endmodule

// File: tb/touch_step_seq_tb.sv
module touch_step_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SMP = 2;
    localparam int NV = 4;
    localparam logic [14:0] VMASK [NV] = '{15'h7FFE, 15'h0015, 15'h4003, 15'h1080};
    localparam int          VWR   [NV] = '{14, 2, 2, 2};

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst_n, wr_en, start, pen_down, adc_done, fifo1_pop;
    logic [5:0] wr_addr;
    logic [31:0] wr_data;
    logic [11:0] adc_data;
    logic adc_start, fifo0_wr, fifo1_wr, irq;
    logic [3:0] adc_chan;
    logic [5:0] panel_drv;
    logic [15:0] fifo_wdata;
    logic [4:0] step_id;
    logic [1:0] irq_raw;

    touch_step_seq u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start(start), .pen_down(pen_down), .adc_done(adc_done), .adc_data(adc_data),
        .fifo1_pop(fifo1_pop), .adc_start(adc_start), .adc_chan(adc_chan),
        .panel_drv(panel_drv), .fifo0_wr(fifo0_wr), .fifo1_wr(fifo1_wr),
        .fifo_wdata(fifo_wdata), .step_id(step_id), .irq_raw(irq_raw), .irq(irq)
    );

    int compared = 0, mismatched = 0;
    logic [15:0] wlog [64];
    logic        wf1  [64];
    logic [4:0]  ssid [64];
    logic [5:0]  sdrv [64];
    logic [3:0]  schan[64];
    int wn = 0, sn = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_f1(input int b);
        return (b >= 7 && b <= 12) || b == 14;
    endfunction
    function automatic logic [5:0] exp_drv(input int b);
        if (b <= 6) return 6'b000011;
        if (b <= 12) return 6'b001100;
        return 6'b000110;
    endfunction
    function automatic logic [31:0] cfg_word(input int b, input int mode);
        return (32'(exp_f1(b)) << 26) | (32'(b) << 16) | (32'(exp_drv(b)) << 5) | 32'(mode);
    endfunction

    // monitor, sampling away from the edge
    always @(negedge clk) begin
        #SMP;
        if (fifo0_wr || fifo1_wr) begin
            if (wn < 64) begin wlog[wn] = fifo_wdata; wf1[wn] = fifo1_wr; end
            wn++;
        end
        if (adc_start) begin
            if (sn < 64) begin ssid[sn] = step_id; sdrv[sn] = panel_drv; schan[sn] = adc_chan; end
            sn++;
        end
    end

    // ADC model: done three cycles after start
    initial begin
        adc_done = 1'b0;
        adc_data = '0;
        forever begin
            @(negedge clk); #SMP;
            if (adc_start) begin
                repeat (3) @(negedge clk);
                adc_data = 12'h500 + 12'(step_id[3:0]) * 12'd3;
                adc_done = 1'b1;
                @(negedge clk);
                adc_done = 1'b0;
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        int c = 0;
        #SMP;
        while (step_id != 5'h10 && c < 3000) begin
            @(negedge clk); #SMP; c++;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int wn0, sn0, cnt, idx;
        bit ok;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        start = 1'b0; pen_down = 1'b1; fifo1_pop = 1'b0;
        repeat (3) @(negedge clk);
        #SMP;
        check(step_id == 5'h10, "R1 step_id", step_id, 5'h10);
        check(panel_drv == 6'd0, "R1 panel_drv", panel_drv, 0);
        check({adc_start, fifo0_wr, fifo1_wr, irq} == 4'b0, "R1 strobes", {adc_start, fifo0_wr, fifo1_wr, irq}, 0);
        check(irq_raw == 2'b00, "R1 irq_raw", irq_raw, 0);
        @(negedge clk); rst_n = 1'b1;

        for (int b = 1; b <= 14; b++) begin
            wr(16 + b, cfg_word(b, 0));
            wr(32 + b, 32'(b));
        end
        wr(1, 32'(6'b001001) << 5);
        wr(2, 32'd1);
        wr(3, 32'(6'b101000) << 5);
        wr(4, 32'd6);
        wr(6, 32'd1);
        #SMP;
        check(panel_drv == 6'b101000, "R5 idle drive", panel_drv, 6'b101000);

        // R10 threshold: five FIFO1 writes, then a sixth
        wr(0, 32'h0F80); pulse_start(); wait_idle();
        check(irq_raw[0] == 1'b0, "R10 below threshold", irq_raw[0], 0);
        wr(0, 32'h1000); pulse_start(); wait_idle();
        check(irq_raw[0] == 1'b1, "R10 threshold reached", irq_raw[0], 1);
        check(irq == 1'b1, "R12 irq enabled", irq, 1);
        wr(5, 32'd1); #SMP;
        check(irq_raw[0] == 1'b0 && irq == 1'b0, "R12 write-one-clear", {irq_raw, irq}, 0);
        @(negedge clk); fifo1_pop = 1'b1;
        repeat (6) @(negedge clk);
        fifo1_pop = 1'b0;

        // vector table: R2, R3, R5
        for (int v = 0; v < NV; v++) begin
            wn = 0; sn = 0;
            wr(0, 32'(VMASK[v]));
            pulse_start(); wait_idle();
            check(wn == VWR[v], "R2 write count", wn, VWR[v]);
            idx = 0;
            for (int b = 1; b <= 14; b++) begin
                if (VMASK[v][b] && idx < wn) begin
                    check(wlog[idx] == {4'(b), 12'h500 + 12'(b * 3)}, "R3 tagged word", wlog[idx], {4'(b), 12'h500 + 12'(b * 3)});
                    check(wf1[idx] == exp_f1(b), "R3 fifo select", wf1[idx], exp_f1(b));
                    check(ssid[idx] == 5'(b), "R4 step order", ssid[idx], b);
                    check(sdrv[idx] == exp_drv(b), "R5 step drive", sdrv[idx], exp_drv(b));
                    check(schan[idx] == 4'(b), "R5 input select", schan[idx], b);
                    idx++;
                end
            end
        end

        // R9 enables cleared: start without rewrite has no effect
        wn0 = wn; sn0 = sn;
        pulse_start();
        repeat (20) @(negedge clk);
        #SMP;
        check(wn == wn0 && sn == sn0 && step_id == 5'h10, "R9 start ignored", sn - sn0, 0);

        // R8 charge step only
        wr(0, 32'h0001);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cnt = 0; ok = 1'b1;
        for (int c = 0; c < 10; c++) begin
            #SMP;
            if (step_id == 5'h0F) begin
                cnt++;
                if (panel_drv != 6'b001001) ok = 1'b0;
            end
            @(negedge clk);
        end
        check(cnt == 2, "R8 charge length", cnt, 2);
        check(ok, "R5 charge drive", ok, 1);

        // R6 open delay
        wr(32 + 5, 32'd9);
        wr(0, 32'h0020);
        pulse_start();
        #SMP;
        check(step_id == 5'd5, "R4 step id shown", step_id, 5);
        cnt = 0;
        while (!adc_start && cnt < 100) begin @(negedge clk); #SMP; cnt++; end
        check(cnt == 11, "R6 open delay", cnt, 11);
        @(negedge clk); #SMP;
        check(adc_start == 1'b0, "R6 single pulse", adc_start, 0);
        wait_idle();

        // R7 hardware sync
        wr(16 + 2, cfg_word(2, 2));
        pen_down = 1'b0;
        wr(0, 32'h0004);
        sn0 = sn;
        pulse_start();
        repeat (30) @(negedge clk);
        #SMP;
        check(step_id == 5'd2 && sn == sn0, "R7 held for pen", step_id, 2);
        @(negedge clk); pen_down = 1'b1;
        wait_idle();
        check(sn == sn0 + 1, "R7 resumes", sn - sn0, 1);
        check(irq_raw[1] == 1'b0, "R11 pen down at end", irq_raw[1], 0);

        // R11 pen-up, R12 masking and per-bit clear
        wr(5, 32'd3);
        wr(6, 32'd0);
        pen_down = 1'b0;
        wr(0, 32'h0002);
        pulse_start(); wait_idle();
        check(irq_raw[1] == 1'b1, "R11 pen-up flag", irq_raw[1], 1);
        check(irq == 1'b0, "R12 masked irq", irq, 0);
        wr(6, 32'd2); #SMP;
        check(irq == 1'b1, "R12 unmasked irq", irq, 1);
        wr(5, 32'd1); #SMP;
        check(irq_raw[1] == 1'b1, "R12 other bit kept", irq_raw[1], 1);
        wr(5, 32'd2); #SMP;
        check(irq_raw == 2'b00 && irq == 1'b0, "R12 pen-up cleared", irq_raw, 0);

        summary();
        $finish;
    end
endmodule